// File: doc/BRIEF.md
# Serial Byte Receiver with Break and Framing Classification

This block turns an asynchronous serial line into bytes. Each frame is one low start bit, eight data bits sent least significant first, and one high stop bit. The line input first passes through a two-flop synchronizer. A bit-period counter then reads every bit once, close to its centre. There is no oversampling and no majority vote. The bit period is the integer ratio of two parameters, `CLK_HZ / BAUD_HZ`, and it may be as short as two clock cycles.

A frame that ends without its stop bit is not simply rejected. If every data bit and the stop bit read low, the receiver counts further bit periods of low line. It reports a line break once the low time reaches `BREAK_BITS` bit periods. `BREAK_BITS` must be at least 10, the length of one frame. If the line rises before that point, or if any data bit was high, it reports a framing error. After a break or an error, it waits for the line to go high before it looks for a new start bit.

The result leaves the block as three single-cycle strobes, with the byte beside them on `rx_byte_o`. A serial line cannot be held off, so this output stream has a valid signal and no ready signal. The consumer must accept each strobe in the cycle it appears. Nothing is kept for a consumer that is not listening.

Top module: `brk_uart_rx`

## Requirements
- R1: `rxd_i` reaches the receive logic only through two flip-flops, so the synchronized line equals `rxd_i` delayed by two clocks.
- R2: A frame with a low start sample and a high stop sample raises `rx_valid_o` for one cycle, and `rx_byte_o` holds the data bits with the first bit received in bit 0.
- R3: The three strobes `rx_valid_o`, `rx_break_o` and `rx_ferr_o` are never high together, and none stays high for two consecutive cycles.
- R4: A low stop sample after at least one high data bit raises `rx_ferr_o` for one cycle, and the received bits stay readable on `rx_byte_o`.
- R5: A frame whose data and stop samples are all low, followed by low samples until `BREAK_BITS` low bit periods (start bit included) have been seen, raises `rx_break_o` once.
- R6: A frame whose data and stop samples are all low, where the line reads high before `BREAK_BITS` low bit periods, raises `rx_ferr_o`, and `rx_byte_o` reads 0x00.
- R7: After a break or framing error the receiver starts no new frame until the line has read high. A low stretch much longer than `BREAK_BITS` gives exactly one strobe.
- R8: A start bit that reads high at its centre sample returns the receiver to idle without any strobe.
- R9: All of the above holds with a bit period of two clock cycles.
- R10: `rst` is synchronous and active high. While it is held and after it is released, all strobes are low and `rx_byte_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| rx_byte_o | output | 8 | Last byte assembled at a stop sample |
| rx_valid_o | output | 1 | One-cycle strobe: good frame received |
| rx_break_o | output | 1 | One-cycle strobe: line break detected |
| rx_ferr_o | output | 1 | One-cycle strobe: framing error |

## Verification
The bench runs two instances side by side, one with a ten-cycle bit period and `BREAK_BITS` of 12, and one with a two-cycle bit period and `BREAK_BITS` of 10. On the two-cycle instance, a design that sampled off-centre would assemble shifted bytes. An all-zero byte with a low stop bit is the sharpest case. It must be a break on the second instance and an error on the first. A design that miscounted the start and stop bits in the low time would swap those outcomes. A long low stretch followed by a good frame catches a receiver that re-arms without waiting for a high line: it would report extra errors or lose the frame. Short low glitches catch a receiver that commits to a frame without checking the start bit, which would emit a spurious strobe.

// File: rtl/brk_uart_rx_pkg.sv
package brk_uart_rx_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK,
    ST_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/brk_uart_rx_sync.sv
module brk_uart_rx_sync (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, stab_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R1
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/brk_uart_rx_timer.sv
module brk_uart_rx_timer #(
  parameter int unsigned BIT_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned HALF_CYC = BIT_CYC / 2;
  localparam int unsigned CW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (arm_i) cnt_q <= CW'(HALF_CYC - 1);
    else if (run_i) begin
      if (cnt_q == '0) cnt_q <= CW'(BIT_CYC - 1);
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  initial begin
    // R9
    min_ratio_chk: assert (BIT_CYC >= 2);
  end
endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx
  import brk_uart_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned BAUD_HZ    = 12_500_000,
  parameter int unsigned BREAK_BITS = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd_i,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       rx_break_o,
  output logic       rx_ferr_o
);
  localparam int unsigned BIT_CYC = CLK_HZ / BAUD_HZ;
  localparam int unsigned LOW_MAX = (BREAK_BITS > FRAME_BITS) ? BREAK_BITS : FRAME_BITS;
  localparam int unsigned LW      = $clog2(LOW_MAX + 1);
  localparam int unsigned IW      = $clog2(DATA_BITS);

  rx_state_e            state_q;
  logic                 line_s;
  logic                 tick;
  logic                 arm, run;
  logic [DATA_BITS-1:0] shift_q;
  logic [IW-1:0]        idx_q;
  logic [LW-1:0]        lowc_q;

  brk_uart_rx_sync u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (line_s)
  );

  assign arm = (state_q == ST_IDLE) && !line_s;
  assign run = (state_q == ST_START) || (state_q == ST_DATA) ||
               (state_q == ST_STOP)  || (state_q == ST_BREAK);

  brk_uart_rx_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (arm),
    .run_i  (run),
    .tick_o (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      idx_q      <= '0;
      lowc_q     <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_break_o <= 1'b0;
      rx_ferr_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      rx_break_o <= 1'b0;
      rx_ferr_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (!line_s) state_q <= ST_START;
        ST_START: if (tick) begin
          if (line_s) state_q <= ST_IDLE;
          else begin
            idx_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (tick) begin
          shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
          if (idx_q == IW'(DATA_BITS - 1)) state_q <= ST_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        ST_STOP: if (tick) begin
          rx_byte_o <= shift_q;
          if (line_s) begin
            rx_valid_o <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (shift_q != '0) begin
            rx_ferr_o <= 1'b1;
            state_q   <= ST_WAIT_HIGH;
          end else if (BREAK_BITS <= FRAME_BITS) begin
            rx_break_o <= 1'b1;
            state_q    <= ST_WAIT_HIGH;
          end else begin
            lowc_q  <= LW'(FRAME_BITS);
            state_q <= ST_BREAK;
          end
        end
        ST_BREAK: if (tick) begin
          if (line_s) begin
            rx_ferr_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (32'(lowc_q) + 1 >= BREAK_BITS) begin
            rx_break_o <= 1'b1;
            state_q    <= ST_WAIT_HIGH;
          end else begin
            lowc_q <= lowc_q + 1'b1;
          end
        end
        ST_WAIT_HIGH: if (line_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid_o, rx_break_o, rx_ferr_o}));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o || rx_break_o || rx_ferr_o) |=> !(rx_valid_o || rx_break_o || rx_ferr_o));

  // R8
  glitch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && tick && line_s) |=> !(rx_valid_o || rx_break_o || rx_ferr_o));

  // R5
  break_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_break_o) |-> ($past(state_q) == ST_STOP || $past(state_q) == ST_BREAK));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_HIGH && !line_s) |=> (state_q == ST_WAIT_HIGH));

  initial begin
    // R5
    break_len_chk: assert (BREAK_BITS >= FRAME_BITS);
  end
endmodule

// File: tb/brk_uart_rx_tb.sv
module brk_uart_rx_tb_top;
  localparam int BIT_A = 10;
  localparam int BIT_B = 2;
  localparam int BRK_A = 12;
  localparam int BRK_B = 10;
  localparam int K_VALID = 0, K_BRK = 1, K_ERR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd_a = 1'b1, rxd_b = 1'b1;
  logic [7:0] byte_a, byte_b;
  logic v_a, b_a, e_a, v_b, b_b, e_b;

  int n_tests = 0, n_fail = 0;
  int cv[2], cb[2], ce[2];
  logic [7:0] last[2];

  always #4 clk = ~clk;

  brk_uart_rx #(.CLK_HZ(125_000_000), .BAUD_HZ(12_500_000), .BREAK_BITS(BRK_A)) dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd_a), .rx_byte_o(byte_a),
    .rx_valid_o(v_a), .rx_break_o(b_a), .rx_ferr_o(e_a));

  brk_uart_rx #(.CLK_HZ(125_000_000), .BAUD_HZ(62_500_000), .BREAK_BITS(BRK_B)) dut_fast_i (
    .clk(clk), .rst(rst), .rxd_i(rxd_b), .rx_byte_o(byte_b),
    .rx_valid_o(v_b), .rx_break_o(b_b), .rx_ferr_o(e_b));

  always @(negedge clk) begin
    if (!rst) begin
      if (v_a) begin cv[0]++; last[0] = byte_a; end
      if (b_a) begin cb[0]++; last[0] = byte_a; end
      if (e_a) begin ce[0]++; last[0] = byte_a; end
      if (v_b) begin cv[1]++; last[1] = byte_b; end
      if (b_b) begin cb[1]++; last[1] = byte_b; end
      if (e_b) begin ce[1]++; last[1] = byte_b; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 2; i++) begin cv[i] = 0; cb[i] = 0; ce[i] = 0; end
  endtask

  task automatic drive(input int sel, input logic lvl, input int bits);
    if (sel == 1) rxd_b = lvl; else rxd_a = lvl;
    repeat (bits * (sel == 1 ? BIT_B : BIT_A)) @(negedge clk);
  endtask

  task automatic send(input int sel, input logic [7:0] d, input logic stop);
    drive(sel, 1'b0, 1);
    for (int i = 0; i < 8; i++) drive(sel, d[i], 1);
    drive(sel, stop, 1);
  endtask

  function automatic int expect_kind(input logic [7:0] d, input logic stop, input int brk);
    if (stop) return K_VALID;
    if (d != 8'h00) return K_ERR;
    if (brk <= 10) return K_BRK;
    return K_ERR;
  endfunction

  task automatic frame_check(input int sel, input logic [7:0] d, input logic stop, input string tag);
    int k;
    k = expect_kind(d, stop, sel == 1 ? BRK_B : BRK_A);
    clr();
    send(sel, d, stop);
    drive(sel, 1'b1, 4);
    chk(cv[sel] == (k == K_VALID) && cb[sel] == (k == K_BRK) && ce[sel] == (k == K_ERR),
        tag, cv[sel] * 100 + cb[sel] * 10 + ce[sel],
        (k == K_VALID) * 100 + (k == K_BRK) * 10 + (k == K_ERR));
    chk(last[sel] == d, {tag, " byte"}, last[sel], d);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    clr();
    repeat (5) @(negedge clk);
    // R10 outputs during reset
    chk(byte_a == 8'h00 && !v_a && !b_a && !e_a, "R10 reset A", byte_a, 0);
    chk(byte_b == 8'h00 && !v_b && !b_b && !e_b, "R10 reset B", byte_b, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(cv[0] + cb[0] + ce[0] + cv[1] + cb[1] + ce[1] == 0, "R10 quiet after reset",
        cv[0] + cb[0] + ce[0], 0);

    // R2 directed and random good frames
    frame_check(0, 8'hA5, 1'b1, "R2 A a5");
    frame_check(0, 8'h01, 1'b1, "R2 A lsb first");
    frame_check(0, 8'h00, 1'b1, "R2 A zero byte");
    frame_check(0, 8'hFF, 1'b1, "R2 A ones");
    for (int i = 0; i < 20; i++) frame_check(0, 8'($urandom), 1'b1, "R2 A random");

    // R9 fast instance, good frames
    frame_check(1, 8'h80, 1'b1, "R9 R2 B msb");
    for (int i = 0; i < 15; i++) frame_check(1, 8'($urandom), 1'b1, "R9 R2 B random");

    // R4 stop low, data nonzero
    frame_check(0, 8'h40, 1'b0, "R4 A ferr");
    frame_check(1, 8'h03, 1'b0, "R4 R9 B ferr");
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'($urandom) | 8'h10;
      frame_check(i % 2, d, 1'b0, "R4 random ferr");
    end

    // R6 all low for ten bits on the long-break instance: error, byte 0
    frame_check(0, 8'h00, 1'b0, "R6 A short low");
    // R5 R9 all low ten bits reaches break length on fast instance
    frame_check(1, 8'h00, 1'b0, "R5 R9 B break");

    // R5 exact break length on instance A
    clr();
    drive(0, 1'b0, BRK_A);
    drive(0, 1'b1, 4);
    chk(cb[0] == 1 && ce[0] == 0 && cv[0] == 0, "R5 A break exact", cb[0] * 10 + ce[0], 10);
    chk(last[0] == 8'h00, "R5 A break byte", last[0], 0);

    // R7 long low gives one strobe, then a good frame
    clr();
    drive(0, 1'b0, 40);
    drive(0, 1'b1, 3);
    chk(cb[0] == 1 && ce[0] == 0 && cv[0] == 0, "R7 A long low", cb[0] * 10 + ce[0], 10);
    frame_check(0, 8'h3C, 1'b1, "R7 A frame after break");
    clr();
    drive(1, 1'b0, 50);
    drive(1, 1'b1, 3);
    chk(cb[1] == 1 && ce[1] == 0 && cv[1] == 0, "R7 R9 B long low", cb[1] * 10 + ce[1], 10);
    // R7 low tail after a framing error does not start a new frame
    clr();
    send(0, 8'h81, 1'b0);
    drive(0, 1'b0, 15);
    drive(0, 1'b1, 3);
    chk(ce[0] == 1 && cb[0] == 0 && cv[0] == 0, "R7 A err then low", ce[0] * 10 + cb[0], 10);

    // R8 glitches shorter than half a bit
    clr();
    for (int g = 1; g <= 3; g++) begin
      rxd_a = 1'b0;
      repeat (g) @(negedge clk);
      rxd_a = 1'b1;
      repeat (3 * BIT_A) @(negedge clk);
    end
    chk(cv[0] + cb[0] + ce[0] == 0, "R8 A glitch", cv[0] + cb[0] + ce[0], 0);
    frame_check(0, 8'h96, 1'b1, "R8 A frame after glitch");
    // R1 one-cycle dip on fast instance is absorbed by the start sample
    clr();
    rxd_b = 1'b0; @(negedge clk); rxd_b = 1'b1;
    repeat (10) @(negedge clk);
    chk(cv[1] + cb[1] + ce[1] == 0, "R1 R8 B one-cycle dip", cv[1] + cb[1] + ce[1], 0);

    // R10 reset mid-frame, then clean frame
    clr();
    rxd_a = 1'b0;
    repeat (3 * BIT_A) @(negedge clk);
    rst = 1'b1; rxd_a = 1'b1;
    @(negedge clk);
    chk(byte_a == 8'h00 && !v_a && !b_a && !e_a, "R10 sync reset", byte_a, 0);
    rst = 1'b0;
    repeat (12 * BIT_A) @(negedge clk);
    chk(cv[0] + cb[0] + ce[0] == 0, "R10 no strobe after reset", cv[0] + cb[0] + ce[0], 0);
    frame_check(0, 8'h5A, 1'b1, "R10 R2 frame after reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150_000) @(negedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule